// File: doc/BRIEF.md
# Programmable Wait-State Sequencer

The sequencer stretches bus cycles on a processor bus that runs off a phase-2 clock. It has one active-high select input per address range. At the start of an access, the winning select picks two bit patterns, and each pattern is loaded in parallel into its own shift register.

The ready register's top bit is the processor's ready line. While that bit is low, both registers shift toward the top bit and take in a 1, so ready stays low for as many cycles as the pattern has leading zeros.

The strobe register's top bit is an active-low strobe enable. It gates the active-low read and write strobes sent to the slow device. Because the two patterns are independent, the strobe can open after some setup cycles and close before ready returns. This gives one continuous strobe pulse rather than a burst of phase-2 pulses.

Both registers change mode on the same condition. They load on every rising phase-2 edge where ready is high and shift on every edge where it is low. The processor samples ready on the falling edge. Decoding addresses into selects happens outside this block.

Top module: `wait_state_seq`

## Requirements
- R1: While `rst_n` is low, both registers hold all ones, so `rdy_o`, `stb_en_n_o`, `rd_n_o` and `wr_n_o` are all 1.
- R2: If ready is high and no select is active at a rising edge, both registers load all ones. Ready then stays 1 and the strobe enable stays inactive (1).
- R3: A ready pattern with k leading zeros (counted from bit W-1) holds `rdy_o` at 0 for exactly k cycles, starting at the loading edge; `rdy_o` returns to 1 on the k-th shift. The default ready patterns are:
  - select 0: 8'h01, 7 waits
  - select 1: 8'hFF, no wait
  - select 2: 8'h3F, 2 waits
  - select 3: 8'h00, 8 waits
- R4: On an edge where `rdy_o` is 0, both registers shift toward bit W-1 and fill bit 0 with 1. Select inputs have no effect on such an edge.
- R5: When several selects are active, the lowest-numbered one chooses both patterns.
- R6: `stb_en_n_o` is the top bit of the strobe register, which loads and shifts on the same edges as the ready register. The default strobe patterns are:
  - select 0: 8'h81
  - select 1: 8'h7F
  - select 2: 8'hBF
  - select 3: 8'h80
- R7: `rd_n_o` is 0 exactly when `stb_en_n_o` is 0 and `rw_i` is 1. `wr_n_o` is 0 exactly when `stb_en_n_o` is 0 and `rw_i` is 0. Both follow `rw_i` without waiting for a clock edge.
- R8: If a select is still active on the edge after ready returns to 1, its patterns load again and a new wait sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ph2 | input | 1 | Phase-2 clock; registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | NSEL | Active-high range selects, bit 0 has highest priority |
| rw_i | input | 1 | Processor direction, 1 = read, 0 = write |
| rdy_o | output | 1 | Ready to the processor, 0 = insert wait |
| stb_en_n_o | output | 1 | Active-low strobe enable |
| rd_n_o | output | 1 | Active-low read strobe to the device |
| wr_n_o | output | 1 | Active-low write strobe to the device |

## Verification
The assertions assume that `sel_i` and `rw_i` change only while `clk_ph2` is low, so that both are stable at the rising edge. They also assume that reset is applied asynchronously and released away from an edge. The stimulus drives every input at the falling edge and releases reset at a falling edge. During wait states it deliberately changes the selects and leaves `rw_i` alone, except in one directed check that turns the strobe direction around mid-wait.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  // Mode code is {c_hi, c_lo}; c_lo is tied high at the top level.
  typedef enum logic [1:0] {
    MODE_HOLD    = 2'b00,
    MODE_UPWARD  = 2'b01,  // shift toward bit W-1, fill bit 0
    MODE_DOWNWARD= 2'b10,  // shift toward bit 0, fill bit W-1
    MODE_LOAD    = 2'b11
  } shift_mode_e;
endpackage

// File: rtl/wsg_pattern_pick.sv
module wsg_pattern_pick #(
  parameter int NSEL = 4,
  parameter int W    = 8,
  parameter logic [NSEL*W-1:0] PATS = '1
) (
  input  logic [NSEL-1:0] sel,
  output logic [W-1:0]    pat
);
  // Descending walk so the lowest-numbered active select is applied last.
  always_comb begin
    pat = '1;
    for (int i = NSEL - 1; i >= 0; i--) begin
      if (sel[i]) pat = PATS[i*W +: W];
    end
  end
endmodule

// File: rtl/wsg_shift_reg.sv
module wsg_shift_reg
  import wsg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  shift_mode_e mode,
  input  logic [W-1:0] par_in,
  input  logic        fill_lo,  // enters bit 0 on upward shift
  input  logic        fill_hi,  // enters bit W-1 on downward shift
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '1;
    end else begin
      unique case (mode)
        MODE_HOLD:     q <= q;
        MODE_UPWARD:   q <= {q[W-2:0], fill_lo};
        MODE_DOWNWARD: q <= {fill_hi, q[W-1:1]};
        MODE_LOAD:     q <= par_in;
        default:       q <= q;
      endcase
    end
  end
endmodule

// File: rtl/wait_state_seq.sv
module wait_state_seq
  import wsg_pkg::*;
#(
  parameter int NSEL = 4,
  parameter int W    = 8,
  parameter logic [NSEL*W-1:0] RDY_PATS = {8'h00, 8'h3F, 8'hFF, 8'h01},
  parameter logic [NSEL*W-1:0] STB_PATS = {8'h80, 8'hBF, 8'h7F, 8'h81}
) (
  input  logic            clk_ph2,
  input  logic            rst_n,
  input  logic [NSEL-1:0] sel_i,
  input  logic            rw_i,
  output logic            rdy_o,
  output logic            stb_en_n_o,
  output logic            rd_n_o,
  output logic            wr_n_o
);
  localparam int TOP = W - 1;

  logic [W-1:0] rdy_pat, stb_pat;
  logic [W-1:0] rdy_q, stb_q;
  shift_mode_e  mode;

  wsg_pattern_pick #(.NSEL(NSEL), .W(W), .PATS(RDY_PATS)) u_pick_rdy (
    .sel(sel_i), .pat(rdy_pat));
  wsg_pattern_pick #(.NSEL(NSEL), .W(W), .PATS(STB_PATS)) u_pick_stb (
    .sel(sel_i), .pat(stb_pat));

  // Ready register's top bit selects load (high) or upward shift (low).
  assign mode = shift_mode_e'({rdy_q[TOP], 1'b1});

  wsg_shift_reg #(.W(W)) u_rdy_sr (
    .clk(clk_ph2), .rst_n(rst_n), .mode(mode), .par_in(rdy_pat),
    .fill_lo(1'b1), .fill_hi(1'b1), .q(rdy_q));
  wsg_shift_reg #(.W(W)) u_stb_sr (
    .clk(clk_ph2), .rst_n(rst_n), .mode(mode), .par_in(stb_pat),
    .fill_lo(1'b1), .fill_hi(1'b1), .q(stb_q));

  assign rdy_o      = rdy_q[TOP];
  assign stb_en_n_o = stb_q[TOP];
  assign rd_n_o     = stb_en_n_o | ~rw_i;
  assign wr_n_o     = stb_en_n_o |  rw_i;

  // R2: idle bus keeps ready high and strobe off
  p_idle_no_wait_r2: assert property (@(posedge clk_ph2) disable iff (!rst_n)
    (rdy_o && sel_i == '0) |=> (rdy_o && stb_en_n_o));

  // R4: every wait edge adds exactly one 1 to the ready register
  p_fill_ones_r4: assert property (@(posedge clk_ph2) disable iff (!rst_n)
    !rdy_o |=> ($countones(rdy_q) == $countones($past(rdy_q)) + 1));

  // R4/R6: strobe register shifts on wait edges regardless of selects
  p_stb_shift_r6: assert property (@(posedge clk_ph2) disable iff (!rst_n)
    !rdy_o |=> ($countones(stb_q) ==
                $countones($past(stb_q)) - int'($past(stb_q[TOP])) + 1));

  // R3: ready can only rise from the last-wait state
  p_rise_from_last_r3: assert property (@(posedge clk_ph2) disable iff (!rst_n)
    $rose(rdy_o) |-> ($past(rdy_q) == {1'b0, {(W-1){1'b1}}}));
endmodule

// File: tb/tb_wait_state_seq.sv
module tb_wait_state_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sel = '0;
  logic       rw = 1'b1;
  logic       rdy, stb_n, rd_n, wr_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  wait_state_seq dut (
    .clk_ph2(clk), .rst_n(rst_n), .sel_i(sel), .rw_i(rw),
    .rdy_o(rdy), .stb_en_n_o(stb_n), .rd_n_o(rd_n), .wr_n_o(wr_n));

  // Entry: {req, sel, rw, exp_rdy, exp_stb_n}
  localparam int NV = 31;
  localparam logic [10:0] VEC [NV] = '{
    {4'd2, 4'b0000, 3'b111},                          // R2 idle
    {4'd3, 4'b0010, 3'b110},                          // R3 sel1 no wait
    {4'd2, 4'b0000, 3'b111},
    {4'd3, 4'b0100, 3'b001},                          // R3 sel2 write
    {4'd4, 4'b1000, 3'b000},                          // R4 sel change ignored
    {4'd3, 4'b0100, 3'b011},
    {4'd2, 4'b0000, 3'b011},
    {4'd6, 4'b0001, 3'b101},                          // R6 sel0 setup cycle
    {4'd6, 4'b0001, 3'b100}, {4'd6, 4'b0001, 3'b100},
    {4'd6, 4'b0001, 3'b100}, {4'd6, 4'b0001, 3'b100},
    {4'd6, 4'b0001, 3'b100}, {4'd6, 4'b0001, 3'b100},
    {4'd6, 4'b0001, 3'b111},                          // R6 hold cycle
    {4'd2, 4'b0000, 3'b111},
    {4'd5, 4'b0110, 3'b110},                          // R5 sel1 beats sel2
    {4'd5, 4'b1100, 3'b101},                          // R5 sel2 beats sel3
    {4'd3, 4'b1100, 3'b100},
    {4'd3, 4'b1100, 3'b111},
    {4'd2, 4'b0000, 3'b111},
    {4'd3, 4'b1000, 3'b001},                          // R3 sel3, 8 waits
    {4'd3, 4'b1000, 3'b000}, {4'd3, 4'b1000, 3'b000},
    {4'd3, 4'b1000, 3'b000}, {4'd3, 4'b1000, 3'b000},
    {4'd3, 4'b1000, 3'b000}, {4'd3, 4'b1000, 3'b000},
    {4'd3, 4'b1000, 3'b000},
    {4'd3, 4'b1000, 3'b011},
    {4'd2, 4'b0000, 3'b011}
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {rdy,stb_n,rd_n,wr_n} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expect4(input logic r, input logic s, input logic w);
    return {r, s, s | ~w, s | w};  // R7 strobe qualification
  endfunction

  task automatic step(input logic [3:0] s, input logic w);
    @(negedge clk);
    sel = s;
    rw = w;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset state", {rdy, stb_n, rd_n, wr_n}, 4'b1111);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6:3], VEC[i][2]);
      chk($sformatf("R%0d table step %0d", VEC[i][10:7], i),
          {rdy, stb_n, rd_n, wr_n}, expect4(VEC[i][1], VEC[i][0], VEC[i][2]));
    end

    // R7: direction flip mid-strobe moves the strobe combinationally
    step(4'b0001, 1'b1);
    step(4'b0001, 1'b1);
    chk("R7 read strobe open", {rdy, stb_n, rd_n, wr_n}, 4'b0001);
    @(negedge clk);
    rw = 1'b0;
    #1;
    chk("R7 write after flip", {rdy, stb_n, rd_n, wr_n}, 4'b0010);

    // R1: reset in the middle of a wait
    rst_n = 1'b0;
    #1;
    chk("R1 reset mid-wait", {rdy, stb_n, rd_n, wr_n}, 4'b1111);
    sel = '0;
    rw = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    step(4'b0000, 1'b1);
    chk("R1 idle after reset", {rdy, stb_n, rd_n, wr_n}, 4'b1111);

    // R8: select held through completion restarts the sequence
    step(4'b0100, 1'b1);
    chk("R8 first wait", {rdy, stb_n}, 2'b01);
    step(4'b0100, 1'b1);
    step(4'b0100, 1'b1);
    chk("R8 ready returns", {rdy, stb_n}, 2'b11);
    step(4'b0100, 1'b1);
    chk("R8 reload", {rdy, stb_n}, 2'b01);
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b1);
    chk("R8 second done", {rdy, stb_n}, 2'b11);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule